// File: doc/BRIEF.md
# PCM Highway Receive Deserializer

This block takes the serial receive lane of a time-division PCM highway and turns each timeslot into a parallel word. The word is announced by a one-cycle valid pulse. The same block keeps a single receive signaling output. That output carries the last bit of the word taken in the most recent signaling frame. The output is pulled low whenever the channel cannot be trusted: just after power-up, in standby, after the master clock stops, and in power-down.

Every pin is asynchronous to the block. Each pin is brought into a fast system clock through a two-stage synchronizer, and the bit-clock edges are found on the synchronized levels. Two timing schemes are supported.

- In fixed mode the master clock also serves as the bit clock. The width of the frame-sync pulse tells a signaling frame from a normal one.
- In variable mode a separate data clock carries the bits. Frame sync acts as a timeslot enable that must stay high for the whole word.

The mode pin is a static strap. It is not resynchronized.

Top module: `pcm_rx_deser`

## Requirements
- R1: After reset, `word_o` is 0 and both `word_vld_o` and `sig_o` are low.
- R2: In fixed mode (`var_mode_i`=0), a rising `fsync_i` arms capture. The next eight falling edges of `mclk_i` each take one bit from `data_i`. The first bit taken becomes `word_o[7]` and the eighth becomes `word_o[0]`. After the eighth bit, `word_o` is loaded and `word_vld_o` is high for exactly one cycle.
- R3: In variable mode (`var_mode_i`=1), bits are taken on falling edges of `dclk_i` while `fsync_i` is high, with the same bit order as R2. `mclk_i` edges do not shift data.
- R4: In variable mode, if `fsync_i` falls before eight bits have been taken, no valid pulse is produced and `word_o` keeps its previous value. The next frame is assembled from its own bits only.
- R5: In fixed mode, a frame is a signaling frame when `fsync_i` is still high at the second bit-clock falling edge (a pulse two master clocks wide). On such a frame `sig_o` takes `word_o[0]`. A frame with a one-clock-wide pulse leaves `sig_o` unchanged.
- R6: A frame received in variable mode never changes `sig_o`.
- R7: After reset, or after leaving standby or power-down, the first `PWRUP_FRAMES` frame-sync rises start frames that cannot update `sig_o`. `sig_o` therefore stays low until a later signaling frame.
- R8: When `fsync_i` has been low for `STANDBY_CYC` system cycles, `sig_o` goes low. It stays low until a qualifying signaling frame (R5, R7) updates it.
- R9: When `mclk_i` has shown no edge for `CLKLOSS_CYC` system cycles, `sig_o` goes low.
- R10: When `pwr_en_i` has been low for `PDN_CYC` system cycles, `sig_o` goes low. While `pwr_en_i` stays low, incoming frames produce no valid pulse and do not change `sig_o`.
- R11: After the eighth bit of a frame, further bit-clock falling edges are ignored until the next `fsync_i` rise. In variable mode a long enable therefore yields one word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock that samples every other input |
| rst_n | input | 1 | Synchronous reset, active low |
| mclk_i | input | 1 | Receive master clock; this is also the bit clock in fixed mode |
| dclk_i | input | 1 | Receive data clock, used in variable mode |
| fsync_i | input | 1 | Frame sync (fixed mode) or timeslot enable (variable mode) |
| data_i | input | 1 | Serial PCM data, most significant bit first |
| pwr_en_i | input | 1 | High keeps the channel active; held low it powers the channel down |
| var_mode_i | input | 1 | Static mode strap: 0 fixed, 1 variable |
| word_o | output | WORD_BITS | Last complete received word |
| word_vld_o | output | 1 | One-cycle pulse when `word_o` is loaded |
| sig_o | output | 1 | Receive signaling bit |

## Verification
Each pin passes two synchronizer stages and an edge-detect register. As a result, `word_vld_o` and the new `word_o` appear three system cycles after the eighth bit-clock fall is driven, and `sig_o` follows one cycle later. The bench therefore samples a frame's results eight or more cycles after the last bit-clock edge. A monitor counts valid pulses and keeps the last word on the falling system edge.

The standby, clock-loss and power-down timeouts are probed twice each. One sample is taken well before the limit, where `sig_o` must still be high. A second is taken a margin after the limit plus the synchronizer delay, where it must be low. No check sits close enough to an edge for a one-cycle shift to matter.

// File: rtl/pcm_rx_pkg.sv
// Shared definitions for the PCM receive deserializer.
// Assumes: pin index constants match the bit order of the synchronized
// pin vector built in the top module.
package pcm_rx_pkg;
    localparam int PIN_CNT  = 5;
    localparam int IX_MCLK  = 0;
    localparam int IX_DCLK  = 1;
    localparam int IX_FS    = 2;
    localparam int IX_DATA  = 3;
    localparam int IX_PWR   = 4;

    // Conditions that force the signaling output low.
    typedef struct packed {
        logic standby;
        logic clk_lost;
        logic pdn;
    } quiet_t;
endpackage

// File: rtl/pcm_rx_sync.sv
// Two-stage level synchronizer, one per input bit.
// Assumes: inputs are asynchronous single-bit levels; each bit is treated
// independently (no bus coherency is implied).
module pcm_rx_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] lvl_o
);
    generate
        for (genvar g = 0; g < W; g++) begin : g_bit
            logic [1:0] stg_q;
            // Move one pin through two flops into the clk domain.
            always_ff @(posedge clk) begin
                if (!rst_n) stg_q <= '0;
                else        stg_q <= {stg_q[0], async_i[g]};
            end
            assign lvl_o[g] = stg_q[1];
        end
    endgenerate
endmodule

// File: rtl/pcm_rx_idle_timer.sv
// Counts consecutive cycles without activity and flags when LIMIT is reached.
// Assumes: activity_i is a synchronized level or pulse; the flag clears on
// the cycle after activity returns.
module pcm_rx_idle_timer #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic activity_i,
    output logic expired_o
);
    localparam int CW = $clog2(LIMIT + 1);
    logic [CW-1:0] cnt_q;

    // Saturating idle counter with a registered expiry flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            expired_o <= 1'b0;
        end else if (activity_i) begin
            cnt_q     <= '0;
            expired_o <= 1'b0;
        end else begin
            if (cnt_q != CW'(LIMIT)) cnt_q <= cnt_q + 1'b1;
            if (cnt_q >= CW'(LIMIT - 1)) expired_o <= 1'b1;
        end
    end
endmodule

// File: rtl/pcm_rx_shift.sv
// Serial-to-parallel word capture for one timeslot.
// Assumes: fs_rise_i, bclk_fall_i are single-cycle pulses from synchronized
// levels; var_mode_i is static while a frame is in flight.
module pcm_rx_shift #(
    parameter int WORD_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable_i,
    input  logic                 var_mode_i,
    input  logic                 fs_lvl_i,
    input  logic                 fs_rise_i,
    input  logic                 bclk_fall_i,
    input  logic                 data_i,
    output logic [WORD_BITS-1:0] word_o,
    output logic                 done_o,
    output logic                 sig_frame_o
);
    localparam int CNT_W = $clog2(WORD_BITS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_BITS - 1);

    logic                 armed_q;
    logic [CNT_W-1:0]     cnt_q;
    logic [WORD_BITS-2:0] shreg_q;
    logic                 sigf_q;
    logic [WORD_BITS-1:0] word_q;
    logic                 done_q;
    logic [WORD_BITS-1:0] next_word;
    logic                 abort;

    assign next_word = {shreg_q, data_i};
    assign abort     = armed_q && var_mode_i && !fs_lvl_i;

    // Arm on sync rise, shift on bit-clock falls, publish after the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
            shreg_q <= '0;
            sigf_q  <= 1'b0;
            word_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!enable_i) begin
                armed_q <= 1'b0;
            end else if (fs_rise_i) begin
                armed_q <= 1'b1;
                cnt_q   <= '0;
                sigf_q  <= 1'b0;
            end else if (abort) begin
                armed_q <= 1'b0;
            end else if (armed_q && bclk_fall_i) begin
                shreg_q <= next_word[WORD_BITS-2:0];
                cnt_q   <= cnt_q + 1'b1;
                if (!var_mode_i && cnt_q == CNT_W'(1) && fs_lvl_i) sigf_q <= 1'b1;
                if (cnt_q == LAST) begin
                    armed_q <= 1'b0;
                    word_q  <= next_word;
                    done_q  <= 1'b1;
                end
            end
        end
    end

    assign word_o      = word_q;
    assign done_o      = done_q;
    assign sig_frame_o = sigf_q;

    // R2
    vld_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R4
    var_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && var_mode_i && !fs_lvl_i && !fs_rise_i) |=> !done_q);
endmodule

// File: rtl/pcm_rx_sig_ctl.sv
// Signaling-bit register with power-up hold, standby, clock-loss and
// power-down forcing.
// Assumes: done_i, sig_frame_i and last_bit_i are valid together in the
// cycle the word completes; fs_rise_i is a single-cycle pulse.
module pcm_rx_sig_ctl #(
    parameter int PWRUP_FRAMES = 4,
    parameter int STANDBY_CYC  = 7500000,
    parameter int CLKLOSS_CYC  = 5000,
    parameter int PDN_CYC      = 2500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fs_lvl_i,
    input  logic fs_rise_i,
    input  logic mclk_edge_i,
    input  logic pwr_lvl_i,
    input  logic done_i,
    input  logic sig_frame_i,
    input  logic last_bit_i,
    output logic sig_o,
    output logic pdn_o
);
    import pcm_rx_pkg::*;

    localparam int FC_W = $clog2(PWRUP_FRAMES + 1);
    localparam logic [FC_W-1:0] FC_MAX = FC_W'(PWRUP_FRAMES);

    quiet_t          q;
    logic [FC_W-1:0] fc_q;
    logic            frame_ok_q;
    logic            sig_q;

    pcm_rx_idle_timer #(.LIMIT(STANDBY_CYC)) u_standby (
        .clk(clk), .rst_n(rst_n), .activity_i(fs_lvl_i), .expired_o(q.standby));
    pcm_rx_idle_timer #(.LIMIT(CLKLOSS_CYC)) u_clkloss (
        .clk(clk), .rst_n(rst_n), .activity_i(mclk_edge_i), .expired_o(q.clk_lost));
    pcm_rx_idle_timer #(.LIMIT(PDN_CYC)) u_pdn (
        .clk(clk), .rst_n(rst_n), .activity_i(pwr_lvl_i), .expired_o(q.pdn));

    // Count frame starts since wake-up and mark frames allowed to update.
    always_ff @(posedge clk) begin
        if (!rst_n || q.pdn) begin
            fc_q       <= '0;
            frame_ok_q <= 1'b0;
        end else if (fs_rise_i) begin
            frame_ok_q <= (fc_q == FC_MAX);
            if (fc_q != FC_MAX) fc_q <= fc_q + 1'b1;
        end else if (q.standby) begin
            fc_q       <= '0;
            frame_ok_q <= 1'b0;
        end
    end

    // Hold the signaling bit, clearing it under any quiet condition.
    always_ff @(posedge clk) begin
        if (!rst_n) sig_q <= 1'b0;
        else if (q.standby || q.clk_lost || q.pdn) sig_q <= 1'b0;
        else if (done_i && sig_frame_i && frame_ok_q) sig_q <= last_bit_i;
    end

    assign sig_o = sig_q;
    assign pdn_o = q.pdn;

    // R8 R9 R10
    quiet_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.standby || q.clk_lost || q.pdn) |=> !sig_q);

    // R7
    hold_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sig_q) |-> $past(frame_ok_q));
endmodule

// File: rtl/pcm_rx_deser.sv
// Top: synchronizes the highway pins, selects the bit clock by mode and
// joins word capture with signaling control.
// Assumes: clk is several times faster than any bit or master clock, and
// var_mode_i is a static strap.
module pcm_rx_deser #(
    parameter int WORD_BITS    = 8,
    parameter int PWRUP_FRAMES = 4,
    parameter int STANDBY_CYC  = 7500000,
    parameter int CLKLOSS_CYC  = 5000,
    parameter int PDN_CYC      = 2500
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mclk_i,
    input  logic                 dclk_i,
    input  logic                 fsync_i,
    input  logic                 data_i,
    input  logic                 pwr_en_i,
    input  logic                 var_mode_i,
    output logic [WORD_BITS-1:0] word_o,
    output logic                 word_vld_o,
    output logic                 sig_o
);
    import pcm_rx_pkg::*;

    logic [PIN_CNT-1:0] pins_raw;
    logic [PIN_CNT-1:0] pins;
    logic [2:0]         prev_q;
    logic               mclk_fall, mclk_edge, dclk_fall, fs_rise, bclk_fall;
    logic               done, sig_frame, pdn;

    assign pins_raw[IX_MCLK] = mclk_i;
    assign pins_raw[IX_DCLK] = dclk_i;
    assign pins_raw[IX_FS]   = fsync_i;
    assign pins_raw[IX_DATA] = data_i;
    assign pins_raw[IX_PWR]  = pwr_en_i;

    pcm_rx_sync #(.W(PIN_CNT)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(pins_raw), .lvl_o(pins));

    // Delay the clock and sync levels one cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= {pins[IX_FS], pins[IX_DCLK], pins[IX_MCLK]};
    end

    assign mclk_fall = prev_q[0] && !pins[IX_MCLK];
    assign mclk_edge = prev_q[0] != pins[IX_MCLK];
    assign dclk_fall = prev_q[1] && !pins[IX_DCLK];
    assign fs_rise   = !prev_q[2] && pins[IX_FS];
    assign bclk_fall = var_mode_i ? dclk_fall : mclk_fall;

    pcm_rx_shift #(.WORD_BITS(WORD_BITS)) u_shift (
        .clk(clk), .rst_n(rst_n), .enable_i(!pdn), .var_mode_i(var_mode_i),
        .fs_lvl_i(pins[IX_FS]), .fs_rise_i(fs_rise), .bclk_fall_i(bclk_fall),
        .data_i(pins[IX_DATA]), .word_o(word_o), .done_o(done),
        .sig_frame_o(sig_frame));

    pcm_rx_sig_ctl #(
        .PWRUP_FRAMES(PWRUP_FRAMES), .STANDBY_CYC(STANDBY_CYC),
        .CLKLOSS_CYC(CLKLOSS_CYC), .PDN_CYC(PDN_CYC)
    ) u_sig (
        .clk(clk), .rst_n(rst_n), .fs_lvl_i(pins[IX_FS]), .fs_rise_i(fs_rise),
        .mclk_edge_i(mclk_edge), .pwr_lvl_i(pins[IX_PWR]), .done_i(done),
        .sig_frame_i(sig_frame), .last_bit_i(word_o[0]), .sig_o(sig_o),
        .pdn_o(pdn));

    assign word_vld_o = done;

    // R5
    sig_after_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sig_o) |-> $past(word_vld_o));

    // R6
    sig_fixed_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sig_o) |-> !var_mode_i);

    // R10
    pdn_no_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pdn |-> !word_vld_o);
endmodule

// File: tb/pcm_rx_deser_tb_top.sv
module pcm_rx_deser_tb_top;
    localparam int WB  = 8;
    localparam int PUF = 4;
    localparam int SBY = 2000;
    localparam int CLL = 300;
    localparam int PDC = 100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mclk = 1'b0, dclk = 1'b0, fsync = 1'b0, data = 1'b0;
    logic pwr_en = 1'b1, var_mode = 1'b0;
    logic [WB-1:0] word_o;
    logic word_vld_o, sig_o;

    int checks = 0, fails = 0;
    int vld_cnt = 0, dbl_vld = 0;
    logic [WB-1:0] mon_word = '0;
    logic vld_prev = 1'b0;
    bit mclk_run = 1'b1;
    int div = 0;
    int hold_cnt = 0;
    bit sig_exp = 1'b0;
    bit pwr_on = 1'b1;
    logic [WB-1:0] last_exp = '0;

    always #2 clk = ~clk;

    pcm_rx_deser #(.WORD_BITS(WB), .PWRUP_FRAMES(PUF), .STANDBY_CYC(SBY),
                   .CLKLOSS_CYC(CLL), .PDN_CYC(PDC)) dut_i (
        .clk(clk), .rst_n(rst_n), .mclk_i(mclk), .dclk_i(dclk),
        .fsync_i(fsync), .data_i(data), .pwr_en_i(pwr_en),
        .var_mode_i(var_mode), .word_o(word_o), .word_vld_o(word_vld_o),
        .sig_o(sig_o));

    // Master clock: period of 8 system cycles, can be stopped.
    always @(negedge clk) begin
        if (mclk_run) begin
            div = div + 1;
            if (div == 4) begin
                div = 0;
                mclk = ~mclk;
            end
        end
    end

    // Output monitor away from the active edge.
    always @(negedge clk) begin
        if (word_vld_o) begin
            vld_cnt = vld_cnt + 1;
            mon_word = word_o;
            if (vld_prev) dbl_vld = dbl_vld + 1;
        end
        vld_prev = word_vld_o;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Frame results: valid count, word and signaling bit.
    task automatic frame_chk(input int base, input int exp_dv, input logic [WB-1:0] w,
                             input string req);
        chk(vld_cnt - base == exp_dv, req, vld_cnt - base, exp_dv);
        if (exp_dv > 0) begin
            last_exp = w;
        end
        chk(mon_word == last_exp, req, int'(mon_word), int'(last_exp));
        chk(sig_o == sig_exp, req, int'(sig_o), int'(sig_exp));
    endtask

    task automatic send_fixed(input logic [WB-1:0] w, input bit wide, input string req);
        int base = vld_cnt;
        var_mode = 1'b0;
        @(posedge mclk);
        fsync = 1'b1;
        data = w[WB-1];
        for (int i = 1; i < WB; i++) begin
            @(posedge mclk);
            fsync = (i == 1) ? wide : 1'b0;
            data = w[WB-1-i];
        end
        @(negedge mclk);
        @(posedge mclk);
        data = 1'b0;
        if (pwr_on) begin
            if (wide && hold_cnt >= PUF) sig_exp = w[0];
            hold_cnt++;
        end
        wait_cyc(8);
        frame_chk(base, pwr_on ? 1 : 0, w, req);
    endtask

    task automatic send_var(input logic [WB-1:0] w, input int nbits, input string req);
        int base = vld_cnt;
        @(negedge clk);
        var_mode = 1'b1;
        fsync = 1'b1;
        wait_cyc(4);
        for (int i = 0; i < nbits; i++) begin
            data = (i < WB) ? w[WB-1-i] : ~data;
            wait_cyc(3);
            dclk = 1'b1;
            wait_cyc(4);
            dclk = 1'b0;
            wait_cyc(1);
        end
        wait_cyc(3);
        fsync = 1'b0;
        data = 1'b0;
        if (pwr_on) hold_cnt++;
        wait_cyc(10);
        frame_chk(base, (nbits >= WB && pwr_on) ? 1 : 0, w, req);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        wait_cyc(10);
        rst_n = 1'b1;
        wait_cyc(3);
        // R1 reset state
        chk(word_o == '0, "R1 word", int'(word_o), 0);
        chk(word_vld_o == 1'b0, "R1 valid", int'(word_vld_o), 0);
        chk(sig_o == 1'b0, "R1 sig", int'(sig_o), 0);

        // R7 power-up hold, R2 fixed capture
        for (int k = 0; k < PUF; k++) send_fixed(8'h31 + 8'(k * 2), 1'b1, "R7 hold");
        send_fixed(8'hA5, 1'b1, "R5 signaling update");
        send_fixed(8'h3C, 1'b0, "R5 single-wide no update");
        send_fixed(8'h80, 1'b1, "R2 msb first");
        send_fixed(8'h01, 1'b1, "R2 lsb last");

        // R3 variable capture, R6 no signaling change
        send_var(8'hC6, WB, "R3 var word");
        chk(sig_o == 1'b1, "R6 var keeps sig", int'(sig_o), 1);
        // R4 short frame discarded, next frame clean
        send_var(8'h5A, 5, "R4 abort");
        send_var(8'h96, WB, "R4 after abort");
        // R11 extra bits ignored
        send_var(8'h3B, WB + 4, "R11 extra bits");
        chk(dbl_vld == 0, "R2 one-cycle valid", dbl_vld, 0);

        // Random mix
        for (int k = 0; k < 40; k++) begin
            logic [WB-1:0] w;
            w = WB'($urandom);
            if ($urandom % 3 == 0) send_var(w, WB, "R3 random var");
            else send_fixed(w, 1'($urandom), "R5 random fixed");
        end
        send_fixed(8'h47, 1'b1, "R5 set before timeouts");

        // R9 clock loss
        @(negedge clk);
        mclk_run = 1'b0;
        wait_cyc(200);
        chk(sig_o == 1'b1, "R9 before limit", int'(sig_o), 1);
        wait_cyc(150);
        chk(sig_o == 1'b0, "R9 after limit", int'(sig_o), 0);
        sig_exp = 1'b0;
        mclk_run = 1'b1;
        wait_cyc(16);
        send_fixed(8'h6D, 1'b1, "R9 recovers");

        // R8 standby
        wait_cyc(1400);
        chk(sig_o == 1'b1, "R8 before limit", int'(sig_o), 1);
        wait_cyc(800);
        chk(sig_o == 1'b0, "R8 after limit", int'(sig_o), 0);
        sig_exp = 1'b0;
        hold_cnt = 0;
        for (int k = 0; k < PUF; k++) send_fixed(8'hF1, 1'b1, "R7 hold after standby");
        send_fixed(8'hE3, 1'b1, "R8 update after wake");

        // R10 power-down
        @(negedge clk);
        pwr_en = 1'b0;
        wait_cyc(60);
        chk(sig_o == 1'b1, "R10 before limit", int'(sig_o), 1);
        wait_cyc(90);
        chk(sig_o == 1'b0, "R10 after limit", int'(sig_o), 0);
        sig_exp = 1'b0;
        pwr_on = 1'b0;
        send_fixed(8'hFF, 1'b1, "R10 frame ignored");
        pwr_en = 1'b1;
        pwr_on = 1'b1;
        hold_cnt = 0;
        wait_cyc(10);
        for (int k = 0; k < PUF; k++) send_fixed(8'h0F, 1'b1, "R7 hold after power-down");
        send_fixed(8'h1B, 1'b1, "R10 update after wake");

        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end
endmodule